// File: doc/BRIEF.md
# Packet-Start Byte Pattern Matcher

This block sits in a 64-bit packet stream. Each beat carries a valid qualifier and start-of-packet and end-of-packet strobes. The block looks for one fixed byte sequence at a fixed byte distance from the packet start. The stream passes through a register delay line that is deep enough to hold the whole search window. When the first beat of a packet leaves the block, the result for that packet comes out beside it. The downstream consumer can therefore route or drop the packet before it has seen any of its bytes.

The pattern value, its byte offset, its length and a per-byte mask are all parameters. A pattern may cross the boundary between two beats. The delay line moves only on valid beats, so idle cycles in the stream leave the alignment between data and result unchanged. If a packet ends before the beat that would hold the last pattern byte, that packet never matches.

Top module: `pkt_pattern_match`

## Requirements
- R1: While rst_n is low, and on the cycle after it is released, out_valid, out_sop, out_eop and out_match are all 0.
- R2: An accepted beat (in_valid high) leaves the block on out_data, out_sop and out_eop with out_valid high. This happens right after the clock edge that accepts the WIN_BEATS-th (default 16) later valid beat. Before that many beats have been accepted since reset, out_valid stays 0.
- R3: A cycle with in_valid low moves nothing through the block. After such an edge, out_valid, out_sop, out_eop and out_match are 0 and out_data holds its previous value.
- R4: Byte lanes are big-endian. Byte n of a packet sits in beat n/8, counted from the start-of-packet beat, at bits [63-8*(n%8) -: 8].
- R5: out_match is 1 together with out_sop exactly when packet bytes PAT_OFS to PAT_OFS+PAT_LEN-1 equal the pattern in every byte whose mask bit is set. Pattern byte i is PATTERN[8*(PAT_LEN-1-i) +: 8], so the first byte is in the top bits. Otherwise out_match is 0 with out_sop.
- R6: A pattern byte whose mask bit PAT_MASK[PAT_LEN-1-i] is 0 has no effect. Any value in that byte position leaves the result unchanged.
- R7: A pattern whose bytes cross a beat boundary is compared across both beats. The default offset 45 with length 6 covers lanes 5 to 7 of beat 5 and lanes 0 to 2 of beat 6.
- R8: If end-of-packet is set on any beat of the packet before the beat holding the last pattern byte, out_match is 0 for that packet, even when the following bytes happen to equal the pattern. End-of-packet on that last beat itself still allows a match.
- R9: out_match is 0 on every cycle where out_sop is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat qualifier |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_data | input | 64 | Input beat, byte 0 in bits 63:56 |
| out_valid | output | 1 | Delayed beat qualifier |
| out_sop | output | 1 | Delayed start-of-packet |
| out_eop | output | 1 | Delayed end-of-packet |
| out_data | output | 64 | Delayed beat |
| out_match | output | 1 | Pattern result for the packet starting on this beat |

## Verification
Each result is counted in valid beats, not clock cycles. The bench numbers every accepted beat. After the edge that accepts beat k, it expects beat k-16 on the outputs, together with that beat's match result when it is a start beat. After an idle edge it expects no valid output and unchanged data. Every output is sampled 1 ns after the rising edge. The reference for the match comes from the bench's own stored beats: the byte slicing, the mask and the early end-of-packet rule are all rebuilt from the requirements.

// File: rtl/pm_pkg.sv
package pm_pkg;
    localparam int LANE_W = 8;
    localparam int LANES  = 8;
    localparam int WORD_W = LANE_W * LANES;

    typedef struct packed {
        logic              vld;
        logic              sop;
        logic              eop;
        logic [WORD_W-1:0] data;
    } beat_t;
endpackage

// File: rtl/pm_beat_pipe.sv
module pm_beat_pipe
    import pm_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  adv,
    input  beat_t in_beat,
    output beat_t win [DEPTH]
);
    beat_t stage_d [DEPTH];
    beat_t stage_q [DEPTH];

    // Shift one slot on every accepted beat; hold otherwise.
    always_comb begin
        stage_d = stage_q;
        if (adv) begin
            stage_d[0] = in_beat;
            for (int i = 1; i < DEPTH; i++) begin
                stage_d[i] = stage_q[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            stage_q <= stage_d;
        end
    end

    assign win = stage_q;
endmodule

// File: rtl/pm_pattern_cmp.sv
module pm_pattern_cmp
    import pm_pkg::*;
#(
    parameter int                      DEPTH    = 16,
    parameter int                      PAT_OFS  = 45,
    parameter int                      PAT_LEN  = 6,
    parameter logic [8*PAT_LEN-1:0]    PATTERN  = 48'hA1B2C3D4E5F6,
    parameter logic [PAT_LEN-1:0]      PAT_MASK = 6'b110111
) (
    input  beat_t win [DEPTH],
    output logic  hit
);
    // Beat (relative to the start beat) that holds the last pattern byte.
    localparam int LAST_B = (PAT_OFS + PAT_LEN - 1) / LANES;

    logic [PAT_LEN-1:0] byte_ok;
    logic [LAST_B:0]    eop_seen;
    logic               unused_win;

    // The start beat sits in the oldest slot; beat b of the packet is b slots younger.
    for (genvar i = 0; i < PAT_LEN; i++) begin : g_byte
        localparam int POS  = PAT_OFS + i;
        localparam int BEAT = POS / LANES;
        localparam int LANE = POS % LANES;
        localparam int SLOT = DEPTH - 1 - BEAT;
        localparam logic [LANE_W-1:0] WANT = PATTERN[LANE_W*(PAT_LEN-1-i) +: LANE_W];
        assign byte_ok[i] = !PAT_MASK[PAT_LEN-1-i]
                         || (win[SLOT].data[LANE_W*(LANES-1-LANE) +: LANE_W] == WANT);
    end

    // End-of-packet on any beat before the last pattern beat voids the match.
    for (genvar k = 0; k < LAST_B; k++) begin : g_eop
        assign eop_seen[k] = win[DEPTH-1-k].eop;
    end
    assign eop_seen[LAST_B] = 1'b0;

    assign hit = (&byte_ok) && !(|eop_seen);

    always_comb begin
        unused_win = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            unused_win = unused_win ^ (^win[i]);
        end
    end
endmodule

// File: rtl/pkt_pattern_match.sv
module pkt_pattern_match
    import pm_pkg::*;
#(
    parameter int                      WIN_BEATS = 16,
    parameter int                      PAT_OFS   = 45,
    parameter int                      PAT_LEN   = 6,
    parameter logic [8*PAT_LEN-1:0]    PATTERN   = 48'hA1B2C3D4E5F6,
    parameter logic [PAT_LEN-1:0]      PAT_MASK  = 6'b110111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [WORD_W-1:0] in_data,
    output logic              out_valid,
    output logic              out_sop,
    output logic              out_eop,
    output logic [WORD_W-1:0] out_data,
    output logic              out_match
);
    typedef struct packed {
        logic              vld;
        logic              sop;
        logic              eop;
        logic              match;
        logic [WORD_W-1:0] data;
    } out_t;

    beat_t in_beat;
    beat_t win [WIN_BEATS];
    beat_t head;
    logic  hit;
    out_t  out_d;
    out_t  out_q;

    assign in_beat = '{vld: 1'b1, sop: in_sop, eop: in_eop, data: in_data};

    pm_beat_pipe #(.DEPTH(WIN_BEATS)) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (in_valid),
        .in_beat (in_beat),
        .win     (win)
    );

    pm_pattern_cmp #(
        .DEPTH    (WIN_BEATS),
        .PAT_OFS  (PAT_OFS),
        .PAT_LEN  (PAT_LEN),
        .PATTERN  (PATTERN),
        .PAT_MASK (PAT_MASK)
    ) u_cmp (
        .win (win),
        .hit (hit)
    );

    assign head = win[WIN_BEATS-1];

    // The oldest beat leaves on the same edge that a new beat enters.
    always_comb begin
        out_d       = out_q;
        out_d.vld   = 1'b0;
        out_d.sop   = 1'b0;
        out_d.eop   = 1'b0;
        out_d.match = 1'b0;
        if (in_valid && head.vld) begin
            out_d.vld   = 1'b1;
            out_d.sop   = head.sop;
            out_d.eop   = head.eop;
            out_d.data  = head.data;
            out_d.match = head.sop && hit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid = out_q.vld;
    assign out_sop   = out_q.sop;
    assign out_eop   = out_q.eop;
    assign out_data  = out_q.data;
    assign out_match = out_q.match;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_match && !out_sop && !out_eop));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_data)));

    // R2
    flags_need_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sop || out_eop) |-> out_valid);

    // R9
    match_needs_sop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_match |-> (out_sop && out_valid));
endmodule

// File: tb/pkt_pattern_match_test.sv
module pkt_pattern_match_test;
    localparam int                 WIN      = 16;
    localparam int                 PAT_OFS  = 45;
    localparam int                 PAT_LEN  = 6;
    localparam logic [47:0]        PATTERN  = 48'hA1B2C3D4E5F6;
    localparam logic [5:0]         PAT_MASK = 6'b110111;
    localparam int                 LAST_B   = (PAT_OFS + PAT_LEN - 1) / 8;
    localparam int                 NB       = 8192;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [63:0] in_data = '0;
    logic        out_valid, out_sop, out_eop, out_match;
    logic [63:0] out_data;

    int          checks = 0, errors = 0, nacc = 0, cycles = 0;
    logic [63:0] bd [NB];
    bit          bs [NB];
    bit          be [NB];
    string       btag [NB];
    string       cur_tag = "";
    logic [7:0]  pb [256];

    always #2 clk = ~clk;

    pkt_pattern_match #(.WIN_BEATS(WIN), .PAT_OFS(PAT_OFS), .PAT_LEN(PAT_LEN),
                        .PATTERN(PATTERN), .PAT_MASK(PAT_MASK)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_data(in_data), .out_valid(out_valid),
        .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data),
        .out_match(out_match));

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit exp_match(int j);
        if (!bs[j]) return 1'b0;
        for (int k = 0; k < LAST_B; k++) if (be[j+k]) return 1'b0;
        for (int i = 0; i < PAT_LEN; i++) begin
            int p = PAT_OFS + i;
            logic [7:0] got = bd[j + p/8][8*(7 - p%8) +: 8];
            if (PAT_MASK[PAT_LEN-1-i] && got != PATTERN[8*(PAT_LEN-1-i) +: 8]) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic step(bit v, bit s, bit e, logic [63:0] d);
        logic [63:0] prev;
        @(negedge clk);
        in_valid = v; in_sop = s; in_eop = e; in_data = d;
        prev = out_data;
        @(posedge clk);
        #1;
        if (v) begin
            int k = nacc;
            bd[k] = d; bs[k] = s; be[k] = e; btag[k] = cur_tag;
            nacc++;
            if (k >= WIN) begin
                int j = k - WIN;
                bit em = exp_match(j);
                chk(out_valid == 1'b1, "R2 out_valid", 64'(out_valid), 64'd1);
                chk(out_data == bd[j], "R2 out_data", out_data, bd[j]);
                chk({out_sop, out_eop} == {bs[j], be[j]}, "R2 sop/eop",
                    64'({out_sop, out_eop}), 64'({bs[j], be[j]}));
                if (bs[j]) chk(out_match == em, {btag[j], " match"}, 64'(out_match), 64'(em));
                else       chk(out_match == 1'b0, "R9 match without sop", 64'(out_match), 64'd0);
            end else begin
                chk(out_valid == 1'b0, "R2 early out_valid", 64'(out_valid), 64'd0);
            end
        end else begin
            chk(out_valid == 1'b0, "R3 idle out_valid", 64'(out_valid), 64'd0);
            chk(out_data == prev, "R3 idle out_data", out_data, prev);
            chk(out_match == 1'b0, "R9 idle match", 64'(out_match), 64'd0);
        end
    endtask

    task automatic fill_random(int nb);
        for (int i = 0; i < nb*8; i++) pb[i] = 8'($urandom);
    endtask

    task automatic put_pattern();
        for (int i = 0; i < PAT_LEN; i++) pb[PAT_OFS+i] = PATTERN[8*(PAT_LEN-1-i) +: 8];
    endtask

    task automatic send_packet(int nb, bit bubbles);
        for (int b = 0; b < nb; b++) begin
            logic [63:0] d;
            if (bubbles && ($urandom % 4) == 0) step(1'b0, 1'b0, 1'b0, 64'($urandom));
            for (int l = 0; l < 8; l++) d[8*(7-l) +: 8] = pb[8*b + l];
            step(1'b1, b == 0, b == nb - 1, d);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                checks++; errors++;
                $display("FAIL watchdog actual=%0d expected=<100000", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(posedge clk);
        #1;
        chk({out_valid, out_sop, out_eop, out_match} == 4'b0, "R1 in reset",
            64'({out_valid, out_sop, out_eop, out_match}), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk({out_valid, out_sop, out_eop, out_match} == 4'b0, "R1 after release",
            64'({out_valid, out_sop, out_eop, out_match}), 64'd0);

        // Exact pattern, crosses the beat 5 / beat 6 boundary
        cur_tag = "R4 R5 R7"; fill_random(8); put_pattern(); send_packet(8, 1'b0);
        // Masked byte differs: still a match
        cur_tag = "R6"; fill_random(9); put_pattern(); pb[PAT_OFS+2] = ~pb[PAT_OFS+2];
        send_packet(9, 1'b0);
        // Unmasked byte differs: no match
        cur_tag = "R5 mismatch"; fill_random(8); put_pattern(); pb[PAT_OFS+4] ^= 8'h01;
        send_packet(8, 1'b0);
        // Packet ends at beat 5; next packet supplies the pattern tail bytes
        cur_tag = "R8 early eop"; fill_random(6); put_pattern(); send_packet(6, 1'b0);
        cur_tag = "R8 tail packet"; fill_random(8); put_pattern();
        for (int i = 0; i < 3; i++) pb[i] = PATTERN[8*(2-i) +: 8];
        send_packet(8, 1'b0);
        // End-of-packet on the last pattern beat still matches
        cur_tag = "R8 eop on last beat"; fill_random(7); put_pattern(); send_packet(7, 1'b0);
        // Idle run in the middle of traffic
        cur_tag = "R3";
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b0, 64'($urandom));
        cur_tag = "R5 one-beat"; fill_random(1); send_packet(1, 1'b0);

        // Random traffic
        for (int n = 0; n < 300; n++) begin
            int nb = 1 + int'($urandom % 18);
            cur_tag = "R5 random";
            fill_random(nb);
            if (nb > LAST_B && ($urandom % 2) == 0) begin
                put_pattern();
                if (($urandom % 4) == 0) pb[PAT_OFS + int'($urandom % PAT_LEN)] ^= 8'h10;
                if (($urandom % 4) == 0) pb[PAT_OFS + 2] = 8'($urandom);
            end
            send_packet(nb, 1'b1);
        end

        // Drain with non-packet filler beats
        cur_tag = "R2 drain";
        for (int i = 0; i < WIN + 1; i++) step(1'b1, 1'b0, 1'b0, 64'($urandom));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule